// File: doc/BRIEF.md
# Change-of-State Digital Input Controller

This block gathers 48 single-bit digital inputs and presents them on a small byte-wide port bus with a 3-bit address and separate read and write strobes. Each input passes through a two-flop synchroniser. The synchronised levels can be read as six bytes, and any level change on a channel can raise an interrupt.

The channels form six groups of eight. Software writes a six-bit mask that allows change interrupts for each group. When an allowed group sees an edge in either direction, a sticky group flag is set and the interrupt output goes high. One status read reports the flags and an active-low pending bit, then clears the flags. An edge that lands in the same cycle as that read is kept.

Top module: `cos_input_ctrl`

## Requirements
- R1: Input bytes are read at offsets 0, 1, 2, 4, 5 and 6 for groups 0 to 5, with bit n of a byte holding channel group*8+n. Offset 3 reads 0x00. `rdata` is valid while `rd_en` is high and is 0x00 otherwise.
- R2: A level change on `din` shows up in the read data after exactly two rising clock edges, not after one.
- R3: Both a rising and a falling transition on a channel set its group flag.
- R4: A write to offset 7 loads `wdata[5:0]` as the group enable mask, where bit k enables group k (channels 8k to 8k+7). An edge in a group whose bit is clear sets no flag.
- R5: After reset the enable mask and all group flags are zero, `irq` is low, and a status read returns 0x40.
- R6: An edge in a group that is disabled when the edge occurs is discarded. Enabling the group later raises no flag.
- R7: A read of offset 7 returns the group flags in bits 5:0, bit 6 = 0 when any flag is set and 1 otherwise, and bit 7 = 0.
- R8: A read of offset 7 clears the group flags, so `irq` is low in the following cycle if no new edge arrives.
- R9: An enabled edge whose detection coincides with the acknowledging read leaves that group's flag set after the read.
- R10: Writes to offsets 0 to 6 change neither the enable mask nor any flag.
- R11: `irq` is high in every cycle in which at least one group flag is set, and it stays high until acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 48 | Asynchronous digital inputs |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Read data, combinational from `addr` while `rd_en` is high |
| irq | output | 1 | Change-of-state interrupt, active high |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that each strobe lasts one cycle per access, so a status read held high for one clock counts as exactly one acknowledge. The bench drives every bus access and every input change on the falling clock edge, and it raises only one strobe at a time. Apart from the deliberate coincidence case, it lets at least three edges pass after an input change before it reads status, so that each expected flag value is fixed before it is sampled.

// File: rtl/cos_pkg.sv
// Package: shared sizes and address constants for the change-of-state input controller.
package cos_pkg;
    parameter int GROUPS   = 6;
    parameter int GRP_W    = 8;
    parameter int ADDR_W   = 3;
    parameter int DATA_W   = 8;
    localparam int NUM_CH  = GROUPS * GRP_W;
    localparam logic [ADDR_W-1:0] GAP_ADDR    = 3'd3;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd7;
    localparam int PEND_BIT = 6;

    // Maps a bus offset to a group index; offsets above the gap shift down by one.
    function automatic int unsigned offset_to_group(input logic [ADDR_W-1:0] a);
        if (a < GAP_ADDR) return int'(a);
        else return int'(a) - 1;
    endfunction
endpackage

// File: rtl/cos_sync_edge.sv
// Module: cos_sync_edge
// Two-flop synchroniser for one group of inputs, plus one history register.
// Reports the settled levels and whether any channel of the group changed.
// Assumes: din is asynchronous to clk; each bit is treated on its own.
module cos_sync_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic         changed
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Two synchroniser stages followed by one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Any bit that differs from its value one clock earlier is an edge.
    always_comb begin
        level   = sync_q;
        changed = |(sync_q ^ hist_q);
    end
endmodule

// File: rtl/cos_flag_latch.sv
// Module: cos_flag_latch
// Holds one sticky change flag per group. Enabled edges set a flag; an acknowledge
// clears all flags except those that receive a new edge in the same cycle.
// Assumes: ack is high for exactly one cycle per status read.
module cos_flag_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic         ack,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    // Per-group sticky flag; a new hit takes priority over the clear.
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[g] <= 1'b0;
            else if (hit[g])     flags_q[g] <= 1'b1;
            else if (ack)        flags_q[g] <= 1'b0;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/cos_bus_regs.sv
// Module: cos_bus_regs
// Byte bus decode: holds the group enable mask and builds the read data from the
// input bytes or the status byte. Flags a status read as an acknowledge.
// Assumes: single-cycle strobes; rd_en and wr_en are never high together.
module cos_bus_regs
    import cos_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  rd_en,
    input  logic [NUM_CH-1:0]     levels,
    input  logic [GROUPS-1:0]     flags,
    output logic [GROUPS-1:0]     en_mask,
    output logic                  ack,
    output logic [DATA_W-1:0]     rdata
);
    logic [GROUPS-1:0] mask_q;
    logic [DATA_W-1:0] status_byte;

    // Enable mask register; only the status offset accepts writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= '0;
        else if (wr_en && addr == STATUS_ADDR) mask_q <= wdata[GROUPS-1:0];
    end

    // Status byte: group flags, active-low pending bit, upper bits zero.
    always_comb begin
        status_byte              = '0;
        status_byte[GROUPS-1:0]  = flags;
        status_byte[PEND_BIT]    = ~|flags;
    end

    // Read multiplexer across the input bytes, the gap and the status register.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == STATUS_ADDR)   rdata = status_byte;
            else if (addr != GAP_ADDR) rdata = levels[offset_to_group(addr)*GRP_W +: GRP_W];
        end
    end

    assign en_mask = mask_q;
    assign ack     = rd_en && (addr == STATUS_ADDR);
endmodule

// File: rtl/cos_input_ctrl.sv
// Module: cos_input_ctrl (top)
// 48-channel change-of-state input controller on an 8-bit port bus.
// Assumes: synchronous active-low reset; one bus strobe at a time.
module cos_input_ctrl
    import cos_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     din,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq
);
    logic [NUM_CH-1:0] levels;
    logic [GROUPS-1:0] grp_change;
    logic [GROUPS-1:0] en_mask;
    logic [GROUPS-1:0] grp_hit;
    logic [GROUPS-1:0] flags;
    logic              ack;

    // One synchroniser and edge detector per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_sync
        cos_sync_edge #(.W(GRP_W)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (din[g*GRP_W +: GRP_W]),
            .level   (levels[g*GRP_W +: GRP_W]),
            .changed (grp_change[g])
        );
    end

    // Only groups that are enabled at the moment of the edge count.
    assign grp_hit = grp_change & en_mask;

    cos_flag_latch #(.N(GROUPS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (grp_hit),
        .ack   (ack),
        .flags (flags)
    );

    cos_bus_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .levels  (levels),
        .flags   (flags),
        .en_mask (en_mask),
        .ack     (ack),
        .rdata   (rdata)
    );

    // Interrupt while any group flag is held.
    assign irq = |flags;
endmodule

// File: rtl/cos_input_ctrl_chk.sv
// Module: cos_input_ctrl_chk
// Property checker bound to cos_input_ctrl. Observes the bus, irq, the enable mask
// and the enabled-edge vector.
module cos_input_ctrl_chk
    import cos_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [GROUPS-1:0] en_mask,
    input logic [GROUPS-1:0] grp_hit
);
    assert_status_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STATUS_ADDR) |-> (rdata[7] == 1'b0));

    assert_pend_low_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STATUS_ADDR) |-> (rdata[PEND_BIT] == !irq));

    assert_gap_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == GAP_ADDR) |-> (rdata == '0));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STATUS_ADDR && grp_hit == '0) |=> !irq);

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && addr == STATUS_ADDR)) |=> irq);

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0 && !irq) |=> !irq);

    assert_other_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != STATUS_ADDR) |=> $stable(en_mask));

    assert_coincident_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STATUS_ADDR && grp_hit != '0) |=> irq);
endmodule

bind cos_input_ctrl cos_input_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq     (irq),
    .en_mask (en_mask),
    .grp_hit (grp_hit)
);

// File: tb/cos_input_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for cos_input_ctrl: one task per scenario, each task checks its own results.
module cos_input_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] din = '0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    cos_input_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    // Records one comparison.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Every task below starts and ends just after a falling edge.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Status read that clears everything left over from an earlier scenario.
    task automatic clear_all();
        logic [7:0] d;
        bus_read(3'd7, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R5 irq after reset", {7'd0, irq}, 8'h00);
        bus_read(3'd7, d);
        check("R5 status after reset", d, 8'h40);
        #1 check("R1 rdata idle", rdata, 8'h00);
    endtask

    task automatic t_read_map();
        logic [7:0] d;
        logic [2:0] offs [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
        din = 48'h81_96_F0_0F_3C_A5;
        step(1);
        bus_read(3'd0, d);
        check("R2 not yet after one edge", d, 8'h00);
        bus_read(3'd0, d);
        check("R2 visible after two edges", d, 8'hA5);
        for (int g = 0; g < 6; g++) begin
            bus_read(offs[g], d);
            check("R1 input byte", d, din[g*8 +: 8]);
        end
        bus_read(3'd3, d);
        check("R1 gap offset", d, 8'h00);
        clear_all();
    endtask

    task automatic t_disabled_ignored();
        logic [7:0] d;
        din = ~din;
        step(4);
        check("R6 irq with mask zero", {7'd0, irq}, 8'h00);
        bus_write(3'd7, 8'h3F);
        step(3);
        check("R6 no late flag", {7'd0, irq}, 8'h00);
        bus_read(3'd7, d);
        check("R6 status clean", d, 8'h40);
    endtask

    task automatic t_edges_ack();
        logic [7:0] d;
        din[9] = ~din[9];
        step(3);
        check("R3 rising or falling sets irq", {7'd0, irq}, 8'h01);
        step(3);
        check("R11 irq held", {7'd0, irq}, 8'h01);
        bus_read(3'd7, d);
        check("R7 status group1", d, 8'h02);
        #1 check("R8 irq cleared", {7'd0, irq}, 8'h00);
        din[47] = 1'b1;
        step(3);
        din[47] = 1'b0;
        step(3);
        bus_read(3'd7, d);
        check("R3 both edges group5", d, 8'h20);
        bus_read(3'd7, d);
        check("R8 status after ack", d, 8'h40);
    endtask

    task automatic t_group_mask();
        logic [7:0] d;
        bus_write(3'd7, 8'h05);
        din[8]  = ~din[8];
        din[20] = ~din[20];
        step(4);
        bus_read(3'd7, d);
        check("R4 only enabled group2", d, 8'h04);
        din[3] = ~din[3];
        step(4);
        bus_read(3'd7, d);
        check("R4 group0 enabled", d, 8'h01);
    endtask

    task automatic t_coincident();
        logic [7:0] d;
        bus_write(3'd7, 8'h3F);
        din[0] = ~din[0];
        step(4);
        din[30] = ~din[30];
        step(2);
        bus_read(3'd7, d);
        check("R9 read shows old group", d, 8'h01);
        #1 check("R9 irq kept", {7'd0, irq}, 8'h01);
        bus_read(3'd7, d);
        check("R9 new flag kept", d, 8'h08);
    endtask

    task automatic t_other_writes();
        logic [7:0] d;
        bus_write(3'd7, 8'h00);
        for (int a = 0; a < 7; a++) bus_write(a[2:0], 8'hFF);
        din[40] = ~din[40];
        step(4);
        check("R10 mask stays zero", {7'd0, irq}, 8'h00);
        bus_write(3'd7, 8'h3F);
        bus_write(3'd5, 8'h00);
        din[16] = ~din[16];
        step(4);
        bus_read(3'd7, d);
        check("R10 mask stays set", d, 8'h04);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_read_map();
        t_disabled_ignored();
        t_edges_ack();
        t_group_mask();
        t_coincident();
        t_other_writes();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule